// File: doc/BRIEF.md
# Write-Only Serial Voltage-Level Register

This block is a receive-only target on a two-wire serial bus of the I2C kind. It holds one six-bit output-voltage level code. Both bus lines are brought into the fast system clock domain through a two-flop synchronizer, and then a third flop keeps the previous sample. The block finds START and STOP conditions and the SCL edges from those samples. A byte engine built around a state machine collects bytes MSB first.

The first byte after a START is compared with the fixed device address 10h, with the read/write bit as bit 0. When it matches, the block is selected and acknowledges every byte it receives after that. The second byte loads a word pointer. Every later byte is a data byte. It is written at the pointer, and then the pointer increments modulo 256.

Only word address 00h holds storage. The stored code selects an output voltage of 1.5 V plus 0.1 V per step, from step 0 to step 40. Values above 40 saturate at 40. The block pulses an update strobe for one clock each time the stored code actually changes.

States of the byte engine:
- ST_IDLE: bus free. No START has been seen yet, or a STOP has been seen.
- ST_ADDR: shift in the address byte.
- ST_ADDR_ACK: pull SDA low for the ninth pulse after a matching address.
- ST_PTR: shift in the word-pointer byte.
- ST_PTR_ACK: acknowledge the pointer byte.
- ST_DATA: shift in a data byte.
- ST_DATA_ACK: acknowledge the data byte.
- ST_IGNORE: the address did not match, so the block stays off the bus.

Transitions of the byte engine:
- START from any state goes to ST_ADDR. This covers a repeated START.
- STOP from any state goes to ST_IDLE.
- The SCL fall after the eighth bit moves ST_ADDR to ST_ADDR_ACK when the address matches, and to ST_IGNORE when it does not.
- The SCL fall after the eighth bit moves ST_PTR to ST_PTR_ACK.
- The SCL fall after the eighth bit moves ST_DATA to ST_DATA_ACK, and the data write happens at the same fall.
- The SCL fall that ends the ninth pulse moves each acknowledge state on: ST_ADDR_ACK goes to ST_PTR, and ST_PTR_ACK and ST_DATA_ACK go to ST_DATA.

Top module: `vsel_i2c_slave`

## Requirements
- R1: After reset, level_code equals the default code 18, sda_pull_low is 0 and level_update is 0.
- R2: A START (SDA falling while SCL is high) begins address reception, and a STOP (SDA rising while SCL is high) returns the block to idle. SDA is sampled on SCL rising edges, MSB first.
- R3: Only the 8-bit address byte 10h (bit 0 = 0 for write) selects the block, and it is acknowledged. Any other value, including 11h (the read form), receives no acknowledge. Later bytes are then neither acknowledged nor stored until the next START.
- R4: While the block is selected, every received byte is acknowledged by sda_pull_low = 1 during the ninth SCL pulse. The pin is released when that pulse ends. sda_pull_low changes only while the synchronized SCL is low, and it is 0 after a STOP.
- R5: The byte after the address loads the word pointer. Each following data byte is written at the pointer, and the pointer then increments modulo 256 (FFh wraps to 00h).
- R6: Data bytes written at any word address other than 00h are acknowledged and leave level_code unchanged.
- R7: A data byte written at word address 00h is stored as the code when its 8-bit value is 40 or less. A larger value stores 40. level_code never exceeds 40.
- R8: level_update is 1 for exactly one clock when level_code takes a new value. It stays 0 when a write stores the value already held.
- R9: A repeated START in the middle of a transaction restarts address reception, also after a rejected address.
- R10: A STOP that arrives before the eighth bit of a data byte leaves level_code unchanged.
- R11: The block operates correctly with SCL high and low phases of at least 8 system clocks each. At 125 MHz this covers 400 kbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 = pull the SDA pad low (open-drain enable) |
| level_code | output | 6 | Stored voltage step, 0 to 40 |
| level_update | output | 1 | One-clock pulse when level_code changes |

## Verification
The hardest situations to reach are those where the word pointer and the bus framing interact. One is a pointer wrap from FFh back to 00h inside a single transaction. Another is a STOP or a repeated START that lands in the middle of a byte or right after a rejected address. The stimulus reaches them with a bit-level bus master. It can send a partial byte and issue START or STOP from any SCL-low point. The pull-low output is resolved against the master through an open-drain model, so every acknowledge is read back from the wired line.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } vsel_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;
endpackage

// File: rtl/vsel_sync.sv
module vsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vsel_bus_events.sv
module vsel_bus_events
    import vsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/vsel_byte_fsm.sv
module vsel_byte_fsm
    import vsel_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    output logic              sda_low,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);

    vsel_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              full_q;
    logic              receiving;
    logic              byte_done;

    assign receiving = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_DATA);
    assign byte_done = receiving && ev.scl_fall && full_q && !ev.start && !ev.stop;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ev.start) begin
            state_d = ST_ADDR;
        end else if (ev.stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_IGNORE:   state_d = ST_IGNORE;
                ST_ADDR:     if (byte_done) state_d = (shreg_q == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_ADDR_ACK: if (ev.scl_fall) state_d = ST_PTR;
                ST_PTR_ACK:  if (ev.scl_fall) state_d = ST_DATA;
                ST_DATA_ACK: if (ev.scl_fall) state_d = ST_DATA;
            endcase
        end
    end

    // state register and receive datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            full_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ev.start || ev.stop || byte_done) begin
                bitcnt_q <= '0;
                full_q   <= 1'b0;
            end else if (receiving && ev.scl_rise) begin
                shreg_q  <= {shreg_q[BYTE_W-2:0], ev.sda};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == CNT_W'(BYTE_W - 1)) begin
                    full_q <= 1'b1;
                end
            end
            if (byte_done && state_q == ST_PTR) begin
                ptr_q <= shreg_q;
            end else if (byte_done && state_q == ST_DATA) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            sda_low <= (state_d == ST_ADDR_ACK) || (state_d == ST_PTR_ACK) ||
                       (state_d == ST_DATA_ACK);
            wr_en   <= byte_done && (state_q == ST_DATA);
            if (byte_done && state_q == ST_DATA) begin
                wr_ptr  <= ptr_q;
                wr_data <= shreg_q;
            end
        end
    end
endmodule

// File: rtl/vsel_level_reg.sv
module vsel_level_reg
    import vsel_pkg::*;
#(
    parameter int                CODE_W       = 6,
    parameter int                MAX_CODE     = 40,
    parameter int                DEFAULT_CODE = 18,
    parameter logic [BYTE_W-1:0] REG_ADDR     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CODE_W-1:0] level,
    output logic              update
);
    localparam logic [BYTE_W-1:0] MAX_B = BYTE_W'(MAX_CODE);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);
    localparam logic [CODE_W-1:0] DEF_C = CODE_W'(DEFAULT_CODE);

    logic [CODE_W-1:0] sat_code;
    logic              hit;

    assign sat_code = (wr_data > MAX_B) ? MAX_C : wr_data[CODE_W-1:0];
    assign hit      = wr_en && (wr_ptr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= DEF_C;
            update <= 1'b0;
        end else begin
            update <= hit && (sat_code != level);
            if (hit) begin
                level <= sat_code;
            end
        end
    end
endmodule

// File: rtl/vsel_i2c_slave.sv
module vsel_i2c_slave
    import vsel_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [BYTE_W-1:0] DEV_ADDR     = 8'h10,
    parameter logic [BYTE_W-1:0] REG_ADDR     = 8'h00,
    parameter int                CODE_W       = 6,
    parameter int                MAX_CODE     = 40,
    parameter int                DEFAULT_CODE = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic [CODE_W-1:0] level_code,
    output logic              level_update
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] pad_raw;
    logic [NLINES-1:0] pad_sync;
    logic              scl_sync;
    logic              sda_sync;
    bus_ev_t           bus_ev;
    logic              ev_stop;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_ptr;
    logic [BYTE_W-1:0] wr_data;

    assign pad_raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        vsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pad_raw[g]),
            .q     (pad_sync[g])
        );
    end

    assign scl_sync = pad_sync[0];
    assign sda_sync = pad_sync[1];

    vsel_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_sync),
        .sda_s (sda_sync),
        .ev    (bus_ev)
    );

    assign ev_stop = bus_ev.stop;

    vsel_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (bus_ev),
        .sda_low (sda_pull_low),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data)
    );

    vsel_level_reg #(
        .CODE_W       (CODE_W),
        .MAX_CODE     (MAX_CODE),
        .DEFAULT_CODE (DEFAULT_CODE),
        .REG_ADDR     (REG_ADDR)
    ) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .level   (level_code),
        .update  (level_update)
    );
endmodule

// File: rtl/vsel_i2c_slave_chk.sv
module vsel_i2c_slave_chk #(
    parameter int CODE_W   = 6,
    parameter int MAX_CODE = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_sync,
    input logic              ev_stop,
    input logic              sda_pull_low,
    input logic [CODE_W-1:0] level_code,
    input logic              level_update
);
    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level_code <= CODE_W'(MAX_CODE)); // R7

    AST_UPDATE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level_update |-> (level_code != $past(level_code))); // R8

    AST_CHANGE_HAS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code != $past(level_code)) |-> level_update); // R8

    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        level_update |=> !level_update); // R8

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_pull_low); // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_low != $past(sda_pull_low)) |-> !scl_sync); // R4
endmodule

bind vsel_i2c_slave vsel_i2c_slave_chk #(
    .CODE_W   (CODE_W),
    .MAX_CODE (MAX_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_sync     (scl_sync),
    .ev_stop      (ev_stop),
    .sda_pull_low (sda_pull_low),
    .level_code   (level_code),
    .level_update (level_update)
);

// File: tb/vsel_i2c_slave_bench.sv
module vsel_i2c_slave_bench;
    localparam int QT = 5; // quarter bit, in clocks: 10-clock SCL phases

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull_low;
    logic [5:0] level_code;
    logic       level_update;
    int         checks = 0;
    int         failures = 0;
    int         upd_cnt = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    vsel_i2c_slave u_vsel_i2c_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .level_code   (level_code),
        .level_update (level_update)
    );

    always @(posedge clk) if (rst_n && level_update) upd_cnt <= upd_cnt + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(QT);
        scl_m = 1'b1; wt(QT);
        sda_m = 1'b0; wt(QT);
        scl_m = 1'b0; wt(QT);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(QT);
        scl_m = 1'b1; wt(QT);
        sda_m = 1'b1; wt(2 * QT);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wt(QT);
            scl_m = 1'b1; wt(2 * QT);
            scl_m = 1'b0; wt(QT);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(QT);
        scl_m = 1'b1; wt(QT);
        ack = !sda_line;
        wt(QT);
        scl_m = 1'b0; wt(QT);
    endtask

    task automatic write_seq(input logic [7:0] ptr, input logic [7:0] d0, input string req);
        bit a;
        bus_start();
        send_byte(8'h10, a); chk(req, "addr ack", a, 1);
        send_byte(ptr, a);   chk(req, "ptr ack", a, 1);
        send_byte(d0, a);    chk(req, "data ack", a, 1);
        bus_stop();
        wt(4);
    endtask

    task automatic t_reset();
        chk("R1", "default level", level_code, 18);
        chk("R1", "sda released", sda_pull_low, 0);
        chk("R1", "no update", level_update, 0);
    endtask

    task automatic t_basic();
        int u0 = upd_cnt;
        // R2 R11: START, address, pointer, data, STOP with 10-clock SCL phases
        write_seq(8'h00, 8'd33, "R5");
        chk("R5", "level after write", level_code, 33);
        chk("R8", "one update", upd_cnt - u0, 1);
        chk("R4", "released after stop", sda_pull_low, 0);
        chk("R11", "fast phases level", level_code, 33);
    endtask

    task automatic t_same();
        int u0 = upd_cnt;
        write_seq(8'h00, 8'd33, "R8");
        chk("R8", "no update on same value", upd_cnt - u0, 0);
        chk("R8", "level kept", level_code, 33);
    endtask

    task automatic t_clamp();
        int u0;
        write_seq(8'h00, 8'd55, "R7");
        chk("R7", "clamped to 40", level_code, 40);
        u0 = upd_cnt;
        write_seq(8'h00, 8'd40, "R7");
        chk("R7", "max stored", level_code, 40);
        chk("R8", "no update clamp-equal", upd_cnt - u0, 0);
        write_seq(8'h00, 8'hC5, "R7");
        chk("R7", "high bits clamp", level_code, 40);
        write_seq(8'h00, 8'd0, "R7");
        chk("R7", "min stored", level_code, 0);
    endtask

    task automatic t_multi();
        bit a;
        bus_start();
        send_byte(8'h10, a); chk("R5", "addr ack", a, 1);
        send_byte(8'h00, a); chk("R5", "ptr ack", a, 1);
        send_byte(8'd10, a); chk("R5", "d0 ack", a, 1);
        send_byte(8'd25, a); chk("R6", "d1 ack at 01h", a, 1);
        bus_stop(); wt(4);
        chk("R5", "auto-increment keeps first", level_code, 10);
    endtask

    task automatic t_wrap();
        bit a;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'hFF, a);
        send_byte(8'd7, a);  chk("R6", "ack at FFh", a, 1);
        wt(2);
        chk("R6", "FFh discarded", level_code, 10);
        send_byte(8'd12, a); chk("R5", "ack after wrap", a, 1);
        bus_stop(); wt(4);
        chk("R5", "wrap to 00h", level_code, 12);
    endtask

    task automatic t_other();
        write_seq(8'h05, 8'd30, "R6");
        chk("R6", "05h discarded", level_code, 12);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(8'h11, a); chk("R3", "read addr nak", a, 0);
        send_byte(8'h00, a); chk("R3", "ignored ptr nak", a, 0);
        send_byte(8'd3, a);  chk("R3", "ignored data nak", a, 0);
        bus_stop(); wt(4);
        chk("R3", "level unchanged", level_code, 12);
        bus_start();
        send_byte(8'h20, a); chk("R3", "wrong addr nak", a, 0);
        bus_stop(); wt(4);
    endtask

    task automatic t_restart();
        bit a;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'h10, a); chk("R9", "addr ack after restart", a, 1);
        send_byte(8'h00, a);
        send_byte(8'd21, a); chk("R9", "data ack", a, 1);
        bus_stop(); wt(4);
        chk("R9", "restart write", level_code, 21);
        bus_start();
        send_byte(8'h12, a); chk("R9", "bad addr nak", a, 0);
        bus_start();
        send_byte(8'h10, a); chk("R9", "ack after rejected", a, 1);
        send_byte(8'h00, a);
        send_byte(8'd22, a);
        bus_stop(); wt(4);
        chk("R9", "write after rejected", level_code, 22);
    endtask

    task automatic t_abort();
        bit a;
        int u0 = upd_cnt;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h00, a);
        send_bits(8'd5, 7);
        bus_stop(); wt(4);
        chk("R10", "partial byte discarded", level_code, 22);
        chk("R10", "no update", upd_cnt - u0, 0);
        chk("R2", "released after stop", sda_pull_low, 0);
    endtask

    initial begin
        wt(5);
        t_reset();
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_basic();
        t_same();
        t_clamp();
        t_multi();
        t_wrap();
        t_other();
        t_bad_addr();
        t_restart();
        t_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule